// File: doc/BRIEF.md
# Serial EEPROM Port Arbiter with Pacing Ready Timer

This block lets software drive a serial EEPROM by bit-banging through one control register, while the EEPROM shares a memory port with another client. Software sets a request bit. As soon as the other client leaves the port idle, the block takes ownership of the port. It then raises a ready flag and starts driving the chip-select, serial clock and serial data-out pins from the register fields. The EEPROM's serial output comes back on a read-only register bit.

After ownership is taken, the ready flag takes on a second job as a pacing timer. Every register write clears it, and it comes back after a fixed number of clock cycles. Software polls the flag between bit-bang steps, so it needs no timer of its own. The first rise of the flag, at grant, comes without any delay. Clearing the request bit deactivates the pins at once and hands the port back one cycle later.

Top module: `eeprom_port_arb`

## Requirements
- R1: During and right after a synchronous reset, `mem_own`, `ee_cs`, `ee_sk`, `ee_mosi` and every bit of `ctl_rdata` are 0.
- R2: A write with `ctl_we` stores request (bit 5), chip select (bit 3), serial clock (bit 2) and data out (bit 1), and these read back at the same positions from the next cycle on. Written values at bits 4 and 0 and above bit 5 have no effect, and bits above 5 read 0.
- R3: `mem_own` rises only at an edge where the stored request is 1 and `mem_busy` is 0. While `mem_busy` stays 1, or the request is 0, `mem_own` stays 0.
- R4: Ready (read bit 4) rises at the same edge as `mem_own`, with no delay.
- R5: While the port is held, a write that keeps the request at 1 clears ready at its edge. Ready then reads 0 for exactly READY_DLY_CYC cycles and is 1 after edge k+READY_DLY_CYC, where k is the write edge.
- R6: A write made while ready is still low restarts the full READY_DLY_CYC window from that write's edge.
- R7: While the port is held, `ee_cs`, `ee_sk` and `ee_mosi` follow register bits 3, 2 and 1, updated at the write edge. When the port is not held, all three are 0.
- R8: While the port is held, read bit 0 shows the `ee_miso` level captured at the previous edge. When the port is not held, it reads 0.
- R9: A write that clears the request zeroes ready and the pins at its edge, and `mem_own` falls one edge later.
- R10: Once the port is held with the request at 1, `mem_busy` has no effect and `mem_own` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | REG_W | Control register write value |
| ctl_rdata | output | REG_W | Control register read value (request, ready, fields, data in) |
| mem_busy | input | 1 | Other memory-port client is active |
| mem_own | output | 1 | Memory port is held for the EEPROM |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_mosi | output | 1 | Serial data toward the EEPROM |
| ee_miso | input | 1 | Serial data from the EEPROM |

## Verification
The bench builds the block with READY_DLY_CYC = 12 and REG_W = 8, instead of the 160-cycle default that gives 800 ns at 200 MHz. With the short window, a random run of a few thousand cycles sees the ready timer expire, restart in mid-window and be cut off by a release many times over. It also sees grants that coincide with busy toggling and with writes that drop the request. The directed part counts the exact low window, and the random part compares every cycle against a model built from the requirements.

// File: rtl/eeprom_arb_pkg.sv
`timescale 1ns/1ps
package eeprom_arb_pkg;
  // Field positions software decodes in the control register
  localparam int unsigned BIT_REQ = 5;
  localparam int unsigned BIT_RDY = 4;
  localparam int unsigned BIT_CS  = 3;
  localparam int unsigned BIT_SK  = 2;
  localparam int unsigned BIT_DO  = 1;
  localparam int unsigned BIT_DI  = 0;

  typedef enum logic {ST_FREE, ST_HELD} arb_state_e;

  typedef struct packed {
    logic cs;
    logic sk;
    logic dout;
  } pin_bits_t;
endpackage

// File: rtl/ee_arb_fsm.sv
`timescale 1ns/1ps
module ee_arb_fsm
  import eeprom_arb_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  input  logic busy_i,
  output logic own_o,
  output logic own_next_o
);
  arb_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_FREE: if (req_i && !busy_i) state_d = ST_HELD;
      ST_HELD: if (!req_i)           state_d = ST_FREE;
      default:                       state_d = ST_FREE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_FREE;
    else     state_q <= state_d;
  end

  assign own_o      = (state_q == ST_HELD);
  assign own_next_o = (state_d == ST_HELD);

  assert_grant_when_idle_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(own_o) |-> $past(req_i && !busy_i));
  assert_release_R9: assert property (@(posedge clk) disable iff (rst)
    (own_o && !req_i) |=> !own_o);
  assert_no_preempt_R10: assert property (@(posedge clk) disable iff (rst)
    (own_o && req_i) |=> own_o);
endmodule

// File: rtl/ee_ready_timer.sv
`timescale 1ns/1ps
module ee_ready_timer #(
  parameter int unsigned DLY = 160
) (
  input  logic clk,
  input  logic rst,
  input  logic keep_i,   // port held and request set after this edge
  input  logic held_i,   // port held before this edge
  input  logic we_i,
  output logic rdy_o
);
  localparam int unsigned CW = (DLY > 1) ? $clog2(DLY) : 1;
  localparam logic [CW:0]   LIM  = (CW+1)'(DLY);
  localparam logic [CW-1:0] LOAD = CW'(DLY - 1);

  logic [CW-1:0] cnt_q;
  logic          rdy_q;

  always_ff @(posedge clk) begin
    if (rst || !keep_i) begin
      rdy_q <= 1'b0;
      cnt_q <= '0;
    end else if (!held_i) begin
      rdy_q <= 1'b1;                 // grant: no pacing delay
      cnt_q <= '0;
    end else if (we_i) begin
      rdy_q <= 1'b0;
      cnt_q <= LOAD;
    end else if (!rdy_q) begin
      if (cnt_q == '0) rdy_q <= 1'b1;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign rdy_o = rdy_q;

  assert_first_rise_R4: assert property (@(posedge clk) disable iff (rst)
    ($rose(held_i) && $past(keep_i)) |-> rdy_q);
  assert_write_drop_R5: assert property (@(posedge clk) disable iff (rst)
    (we_i && held_i && keep_i) |=> !rdy_q);
  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, cnt_q} < LIM));
endmodule

// File: rtl/ee_pin_drive.sv
`timescale 1ns/1ps
module ee_pin_drive
  import eeprom_arb_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      en_i,
  input  pin_bits_t fld_i,
  input  logic      miso_i,
  output pin_bits_t pins_o,
  output logic      din_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pins_o <= '0;
      din_o  <= 1'b0;
    end else begin
      pins_o <= en_i ? fld_i : '0;
      din_o  <= en_i & miso_i;
    end
  end

  assert_din_capture_R8: assert property (@(posedge clk) disable iff (rst)
    $past(en_i) |-> (din_o == $past(miso_i)));
endmodule

// File: rtl/eeprom_port_arb.sv
`timescale 1ns/1ps
module eeprom_port_arb
  import eeprom_arb_pkg::*;
#(
  parameter int unsigned READY_DLY_CYC = 160,
  parameter int unsigned REG_W         = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_we,
  input  logic [REG_W-1:0] ctl_wdata,
  output logic [REG_W-1:0] ctl_rdata,
  input  logic             mem_busy,
  output logic             mem_own,
  output logic             ee_cs,
  output logic             ee_sk,
  output logic             ee_mosi,
  input  logic             ee_miso
);
  logic      req_q, req_d;
  pin_bits_t fld_q, fld_d;
  logic      own_q, own_nx, keep;
  logic      rdy_q, din_q;
  pin_bits_t pins_q;

  always_comb begin
    req_d = ctl_we ? ctl_wdata[BIT_REQ] : req_q;
    fld_d = ctl_we ? pin_bits_t'{cs:   ctl_wdata[BIT_CS],
                                 sk:   ctl_wdata[BIT_SK],
                                 dout: ctl_wdata[BIT_DO]} : fld_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= 1'b0;
      fld_q <= '0;
    end else begin
      req_q <= req_d;
      fld_q <= fld_d;
    end
  end

  ee_arb_fsm u_fsm (
    .clk(clk), .rst(rst), .req_i(req_q), .busy_i(mem_busy),
    .own_o(own_q), .own_next_o(own_nx)
  );

  assign keep = own_nx & req_d;

  ee_ready_timer #(.DLY(READY_DLY_CYC)) u_tmr (
    .clk(clk), .rst(rst), .keep_i(keep), .held_i(own_q),
    .we_i(ctl_we), .rdy_o(rdy_q)
  );

  ee_pin_drive u_drv (
    .clk(clk), .rst(rst), .en_i(keep), .fld_i(fld_d),
    .miso_i(ee_miso), .pins_o(pins_q), .din_o(din_q)
  );

  always_comb begin
    ctl_rdata          = '0;
    ctl_rdata[BIT_REQ] = req_q;
    ctl_rdata[BIT_RDY] = rdy_q;
    ctl_rdata[BIT_CS]  = fld_q.cs;
    ctl_rdata[BIT_SK]  = fld_q.sk;
    ctl_rdata[BIT_DO]  = fld_q.dout;
    ctl_rdata[BIT_DI]  = din_q;
  end

  assign mem_own = own_q;
  assign ee_cs   = pins_q.cs;
  assign ee_sk   = pins_q.sk;
  assign ee_mosi = pins_q.dout;

  assert_field_store_R2: assert property (@(posedge clk) disable iff (rst)
    ctl_we |=> (ctl_rdata[BIT_CS] == $past(ctl_wdata[BIT_CS])));
  assert_pins_idle_R7: assert property (@(posedge clk) disable iff (rst)
    !mem_own |-> (!ee_cs && !ee_sk && !ee_mosi));
  assert_din_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !mem_own |-> !ctl_rdata[BIT_DI]);
  assert_rdy_needs_own_R9: assert property (@(posedge clk) disable iff (rst)
    ctl_rdata[BIT_RDY] |-> mem_own);
endmodule

// File: tb/eeprom_port_arb_bench.sv
`timescale 1ns/1ps
module eeprom_port_arb_bench;
  localparam int unsigned DLY = 12;
  localparam int unsigned W   = 8;

  logic clk = 1'b0, rst = 1'b1, ctl_we = 1'b0, mem_busy = 1'b0, ee_miso = 1'b0;
  logic [W-1:0] ctl_wdata = '0;
  logic [W-1:0] ctl_rdata;
  logic mem_own, ee_cs, ee_sk, ee_mosi;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  eeprom_port_arb #(.READY_DLY_CYC(DLY), .REG_W(W)) u_eeprom_port_arb (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .mem_busy(mem_busy), .mem_own(mem_own),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_mosi(ee_mosi), .ee_miso(ee_miso)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [W-1:0] d);
    ctl_we = 1'b1;
    ctl_wdata = d;
    tick();
    ctl_we = 1'b0;
  endtask

  function automatic logic [W-1:0] exp_reg(input logic req, input logic rdy,
      input logic [2:0] f, input logic di);
    logic [W-1:0] r;
    r = '0;
    r[5] = req; r[4] = rdy; r[3] = f[2]; r[2] = f[1]; r[1] = f[0]; r[0] = di;
    return r;
  endfunction

  // Reference model derived from the requirements
  logic m_req, m_own, m_rdy, m_din;
  logic [2:0] m_fld, m_pins;
  int m_left;

  always @(posedge clk) begin
    logic rq, on, keep;
    logic [2:0] f;
    if (rst) begin
      m_req <= 0; m_own <= 0; m_rdy <= 0; m_din <= 0;
      m_fld <= 0; m_pins <= 0; m_left <= 0;
    end else begin
      rq   = ctl_we ? ctl_wdata[5] : m_req;
      f    = ctl_we ? {ctl_wdata[3], ctl_wdata[2], ctl_wdata[1]} : m_fld;
      on   = m_req && (m_own || !mem_busy);
      keep = on && rq;
      if (!keep) begin m_rdy <= 0; m_left <= 0; end
      else if (!m_own) begin m_rdy <= 1; m_left <= 0; end
      else if (ctl_we) begin m_rdy <= 0; m_left <= DLY; end
      else if (m_left > 0) begin m_left <= m_left - 1; m_rdy <= (m_left == 1); end
      m_req  <= rq;
      m_fld  <= f;
      m_own  <= on;
      m_din  <= keep & ee_miso;
      m_pins <= keep ? f : 3'b000;
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    @(negedge clk);
    rst = 1'b1;
    tick(); tick();
    chk("R1 own in reset", mem_own, 0);
    rst = 1'b0;
    tick();
    chk("R1 rdata after reset", ctl_rdata, 0);
    chk("R1 pins after reset", {ee_cs, ee_sk, ee_mosi}, 0);

    // Request while busy
    mem_busy = 1'b1;
    wr(8'hFF);
    chk("R2 stored fields, ro bits ignored", ctl_rdata, exp_reg(1, 0, 3'b111, 0));
    chk("R7 pins idle before grant", {ee_cs, ee_sk, ee_mosi}, 0);
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R3 no grant while busy", mem_own, 0);
    end

    // Grant
    ee_miso = 1'b0;
    mem_busy = 1'b0;
    tick();
    chk("R3 grant when idle", mem_own, 1);
    chk("R4 ready at grant", ctl_rdata, exp_reg(1, 1, 3'b111, 0));
    chk("R7 pins driven after grant", {ee_cs, ee_sk, ee_mosi}, 3'b111);

    mem_busy = 1'b1;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R10 busy ignored while held", mem_own, 1);
    end

    ee_miso = 1'b1; tick();
    chk("R8 data in high", ctl_rdata[0], 1);
    ee_miso = 1'b0; tick();
    chk("R8 data in low", ctl_rdata[0], 0);

    // Pacing window
    wr(8'h28);
    chk("R5 ready drops on write", ctl_rdata[4], 0);
    chk("R7 pins follow write", {ee_cs, ee_sk, ee_mosi}, 3'b100);
    for (int i = 1; i < DLY; i++) begin
      tick();
      chk("R5 ready still low", ctl_rdata[4], 0);
    end
    tick();
    chk("R5 ready back after window", ctl_rdata[4], 1);

    // Restart mid-window
    wr(8'h2C);
    chk("R7 clock pin set", {ee_cs, ee_sk, ee_mosi}, 3'b110);
    for (int i = 0; i < DLY - 2; i++) begin
      tick();
      chk("R6 low before restart", ctl_rdata[4], 0);
    end
    wr(8'h28);
    for (int i = 1; i < DLY; i++) begin
      tick();
      chk("R6 low after restart", ctl_rdata[4], 0);
    end
    tick();
    chk("R6 ready after restarted window", ctl_rdata[4], 1);

    // Release
    wr(8'h08);
    chk("R9 pins off at clear", {ee_cs, ee_sk, ee_mosi}, 0);
    chk("R9 ready off at clear", ctl_rdata[4], 0);
    chk("R9 own held one more cycle", mem_own, 1);
    ee_miso = 1'b1;
    mem_busy = 1'b0;
    tick();
    chk("R9 own released", mem_own, 0);
    tick();
    chk("R8 data in zero when not held", ctl_rdata, exp_reg(0, 0, 3'b100, 0));
    chk("R3 no grant without request", mem_own, 0);

    // Random phase against the model
    for (int c = 0; c < 4000; c++) begin
      mem_busy  = (($urandom % 3) == 0);
      ee_miso   = $urandom % 2;
      ctl_we    = (($urandom % 6) == 0);
      ctl_wdata = W'($urandom);
      if (($urandom % 8) != 0) ctl_wdata[5] = 1'b1;
      tick();
      chk("R3 random own", mem_own, m_own);
      chk("R5 random ready", ctl_rdata[4], m_rdy);
      chk("R2 random rdata", ctl_rdata, exp_reg(m_req, m_rdy, m_fld, m_din));
      chk("R7 random pins", {ee_cs, ee_sk, ee_mosi}, m_pins);
    end
    ctl_we = 1'b0;

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule